// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block multiplies two 3x3 matrices of signed 8-bit integers, C = A x B, on a square grid of nine multiply-accumulate cells. Every cell owns one entry of the product and keeps it in its own accumulator. Operands march through the grid: A values travel rightward along the rows and B values travel downward along the columns, advancing one cell per clock.

A single-cycle start pulse latches both input matrices from the parallel load ports and clears the nine accumulators. An internal step counter then feeds the left and top edges with a diagonal time skew. Row i of A begins i steps late and column j of B begins j steps late. Because of this skew, a[i][k] and b[k][j] meet in cell (i,j) at step i+j+k+1. Any edge slot with no operand to carry is filled with zero. The last term is added at step 7. After that the block pulses done for one cycle and holds all nine results on its output bus until the next accepted start.

Top module: `osMatMul`

## Requirements
- R1: While reset is held and after it is released, done is 0 and every field of cFlat is 0 until a start is accepted.
- R2: Element a[i][j] is taken from aFlat bits [(i*3+j)*8 +: 8], and b[i][j] from bFlat at the same position. Both are two's-complement values, sampled on the clock edge where start is accepted.
- R3: After a run, field (i,j) of cFlat, at bits [(i*3+j)*18 +: 18] in two's complement, equals the sum over k of a[i][k]*b[k][j].
- R4: done is 1 only in the single cycle after the 7th clock edge that follows the edge accepting start. It is 0 in every other cycle.
- R5: When no start is accepted, cFlat does not change from the cycle in which done rises.
- R6: A start pulse that arrives while a computation is running is ignored. The result and the done timing are those of the run already in progress.
- R7: An accepted start clears all nine results, so cFlat reads 0 in the cycle after the accepting edge.
- R8: Full-range operands (-128 and 127 in every element) produce exact results with no wraparound.
- R9: Changes on aFlat and bFlat at any time other than an accepted start do not affect the results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a multiplication; honoured only when idle |
| aFlat | input | 72 | Matrix A, row-major, 8 bits per element |
| bFlat | input | 72 | Matrix B, row-major, 8 bits per element |
| cFlat | output | 162 | Product C, row-major, 18 bits per element |
| done | output | 1 | One-cycle pulse when the results are final |

## Verification
Some properties are checked by the bound checker on every cycle. These are the control properties: an accepted start moves the sequencer to step 1 and zeroes the results, a start during a run only lets the step count advance, done is preceded by the final step and lasts a single cycle, and the result bus holds steady whenever the block is idle. Only the bench scenarios can show the arithmetic itself. These include the correct pairing of A and B elements under the skew, the exact value of every product entry for signed and full-range operands, and the fact that input changes in mid-run leave the answer untouched. The bench checks these with expected products it computes itself.

// File: rtl/osMatMulPkg.sv
package osMatMulPkg;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic clr;  // latch operands, zero accumulators and pipes
    logic run;  // a computation step is in progress this cycle
  } mmStrobe_t;

endpackage

// File: rtl/osMatMulPe.sv
module osMatMulPe #(
  parameter int OPW  = 8,
  parameter int ACCW = 18
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   clr,
  input  logic                   en,
  input  logic signed [OPW-1:0]  aIn,
  input  logic signed [OPW-1:0]  bIn,
  output logic signed [ACCW-1:0] acc
);
  localparam int PW  = 2 * OPW;
  localparam int EXT = ACCW - PW;

  logic signed [PW-1:0]   prod;
  logic signed [ACCW-1:0] prodExt;

  always_comb begin
    prod    = aIn * bIn;
    prodExt = {{EXT{prod[PW-1]}}, prod};
  end

  always_ff @(posedge clk) begin
    if (!rstN)      acc <= '0;
    else if (clr)   acc <= '0;
    else if (en)    acc <= acc + prodExt;
  end
endmodule

// File: rtl/osMatMulCtrl.sv
module osMatMulCtrl
  import osMatMulPkg::*;
#(
  parameter int DIM    = 3,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output mmStrobe_t         strb,
  output logic [STEP_W-1:0] step,
  output logic              done
);
  // Final step: largest i+j+k+1 over the grid.
  localparam logic [STEP_W-1:0] LAST = STEP_W'(3 * DIM - 2);

  logic busy;

  always_comb begin
    strb.clr = start & ~busy;
    strb.run = busy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      step <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (strb.clr) begin
        busy <= 1'b1;
        step <= STEP_W'(1);
      end else if (busy) begin
        if (step == LAST) begin
          busy <= 1'b0;
          step <= '0;
          done <= 1'b1;
        end else begin
          step <= step + STEP_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/osMatMulDatapath.sv
module osMatMulDatapath
  import osMatMulPkg::*;
#(
  parameter int DIM    = 3,
  parameter int OPW    = 8,
  parameter int ACCW   = 18,
  parameter int STEP_W = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  mmStrobe_t               strb,
  input  logic [STEP_W-1:0]       step,
  input  logic [DIM*DIM*OPW-1:0]  aFlat,
  input  logic [DIM*DIM*OPW-1:0]  bFlat,
  output logic [DIM*DIM*ACCW-1:0] cFlat
);
  logic signed [OPW-1:0] aReg [DIM][DIM];
  logic signed [OPW-1:0] bReg [DIM][DIM];
  logic signed [OPW-1:0] aEdge [DIM];
  logic signed [OPW-1:0] bEdge [DIM];
  logic signed [OPW-1:0] aIn [DIM][DIM];
  logic signed [OPW-1:0] bIn [DIM][DIM];

  // Operand capture on an accepted start.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < DIM; r++)
        for (int c = 0; c < DIM; c++) begin
          aReg[r][c] <= '0;
          bReg[r][c] <= '0;
        end
    end else if (strb.clr) begin
      for (int r = 0; r < DIM; r++)
        for (int c = 0; c < DIM; c++) begin
          aReg[r][c] <= aFlat[(r*DIM+c)*OPW +: OPW];
          bReg[r][c] <= bFlat[(r*DIM+c)*OPW +: OPW];
        end
    end
  end

  // Skewed edge injection: row r of A and column c of B carry element k
  // at step r+k+1 (resp. c+k+1); every other slot is zero.
  always_comb begin
    for (int r = 0; r < DIM; r++) begin
      aEdge[r] = '0;
      for (int k = 0; k < DIM; k++)
        if (strb.run && step == STEP_W'(r + k + 1)) aEdge[r] = aReg[r][k];
    end
    for (int c = 0; c < DIM; c++) begin
      bEdge[c] = '0;
      for (int k = 0; k < DIM; k++)
        if (strb.run && step == STEP_W'(c + k + 1)) bEdge[c] = bReg[k][c];
    end
  end

  for (genvar r = 0; r < DIM; r++) begin : gRow
    for (genvar c = 0; c < DIM; c++) begin : gCol
      logic signed [ACCW-1:0] acc;

      // A operand source: edge in column 0, else the hop register to the left.
      if (c == 0) begin : gAEdge
        assign aIn[r][c] = aEdge[r];
      end else begin : gAHop
        logic signed [OPW-1:0] aHop;
        always_ff @(posedge clk) begin
          if (!rstN || strb.clr) aHop <= '0;
          else if (strb.run)     aHop <= aIn[r][c-1];
        end
        assign aIn[r][c] = aHop;
      end

      // B operand source: edge in row 0, else the hop register above.
      if (r == 0) begin : gBEdge
        assign bIn[r][c] = bEdge[c];
      end else begin : gBHop
        logic signed [OPW-1:0] bHop;
        always_ff @(posedge clk) begin
          if (!rstN || strb.clr) bHop <= '0;
          else if (strb.run)     bHop <= bIn[r-1][c];
        end
        assign bIn[r][c] = bHop;
      end

      osMatMulPe #(.OPW(OPW), .ACCW(ACCW)) uPe (
        .clk  (clk),
        .rstN (rstN),
        .clr  (strb.clr),
        .en   (strb.run),
        .aIn  (aIn[r][c]),
        .bIn  (bIn[r][c]),
        .acc  (acc)
      );

      assign cFlat[(r*DIM+c)*ACCW +: ACCW] = acc;
    end
  end
endmodule

// File: rtl/osMatMul.sv
module osMatMul
  import osMatMulPkg::*;
#(
  parameter int DIM  = 3,
  parameter int OPW  = 8,
  parameter int ACCW = 2 * OPW + $clog2(DIM)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [DIM*DIM*OPW-1:0]  aFlat,
  input  logic [DIM*DIM*OPW-1:0]  bFlat,
  output logic [DIM*DIM*ACCW-1:0] cFlat,
  output logic                    done
);
  localparam int STEP_W = $clog2(3 * DIM) + 1;

  mmStrobe_t         ctrlStrb;
  logic [STEP_W-1:0] stepCnt;

  osMatMulCtrl #(.DIM(DIM), .STEP_W(STEP_W)) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .strb  (ctrlStrb),
    .step  (stepCnt),
    .done  (done)
  );

  osMatMulDatapath #(.DIM(DIM), .OPW(OPW), .ACCW(ACCW), .STEP_W(STEP_W)) uDp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (ctrlStrb),
    .step  (stepCnt),
    .aFlat (aFlat),
    .bFlat (bFlat),
    .cFlat (cFlat)
  );
endmodule

// File: rtl/osMatMulChk.sv
module osMatMulChk #(
  parameter int DIM    = 3,
  parameter int ACCW   = 18,
  parameter int STEP_W = 4
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    start,
  input logic                    busy,
  input logic [STEP_W-1:0]       stepCnt,
  input logic [DIM*DIM*ACCW-1:0] cFlat,
  input logic                    done
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(3 * DIM - 2);

  // R7: accepted start zeroes results and enters step 1
  a_r7_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (cFlat == '0 && busy && stepCnt == STEP_W'(1)));

  // R6: start during a run only advances the step count
  a_r6_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (start && busy && stepCnt != LAST) |=> (busy && stepCnt == $past(stepCnt) + STEP_W'(1)));

  // R4: done follows the final step
  a_r4_done_after_last: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(busy && stepCnt == LAST));

  // R4: done lasts one cycle
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5: idle results hold
  a_r5_results_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(cFlat));

  // R1: no done while a run is active
  a_r1_done_idle_only: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

bind osMatMul osMatMulChk #(.DIM(DIM), .ACCW(ACCW), .STEP_W(STEP_W)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .busy    (ctrlStrb.run),
  .stepCnt (stepCnt),
  .cFlat   (cFlat),
  .done    (done)
);

// File: tb/sim_osMatMul.sv
module sim_osMatMul;
  localparam int CLK_P = 10;
  localparam int N     = 3;
  localparam int OPW   = 8;
  localparam int ACCW  = 18;

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic                  start = 1'b0;
  logic [N*N*OPW-1:0]    aFlat = '0;
  logic [N*N*OPW-1:0]    bFlat = '0;
  logic [N*N*ACCW-1:0]   cFlat;
  logic                  done;

  int nChecks = 0;
  int nFails  = 0;
  int am [N][N];
  int bm [N][N];
  int exp [N][N];
  int unsigned seed = 32'h1234_5678;

  always #(CLK_P/2) clk = ~clk;

  osMatMul u0 (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .aFlat (aFlat),
    .bFlat (bFlat),
    .cFlat (cFlat),
    .done  (done)
  );

  task automatic check(input bit ok, input string req, input int got, input int want);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual %0d expected %0d", req, got, want);
    end
  endtask

  function automatic int cOut(input int r, input int c);
    logic signed [ACCW-1:0] v;
    v = cFlat[(r*N+c)*ACCW +: ACCW];
    return int'(v);
  endfunction

  function automatic int rnd8();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) & 32'hFF) - 128;
  endfunction

  task automatic packAndExpect();
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        aFlat[(r*N+c)*OPW +: OPW] = 8'(am[r][c]);
        bFlat[(r*N+c)*OPW +: OPW] = 8'(bm[r][c]);
        exp[r][c] = 0;
      end
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        for (int k = 0; k < N; k++)
          exp[r][c] += am[r][k] * bm[k][c];
  endtask

  task automatic checkResults(input string req);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        check(cOut(r, c) == exp[r][c], req, cOut(r, c), exp[r][c]);
  endtask

  // One full run; optionally disturb start and operands mid-run.
  task automatic runCase(input bit disturb, input string req);
    packAndExpect();
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    check(cOut(0, 0) == 0 && cOut(N-1, N-1) == 0, "R7 clear", cOut(N-1, N-1), 0);
    for (int n = 1; n <= 7; n++) begin
      if (disturb && n == 3) begin
        start = 1'b1;          // R6: must be ignored
        aFlat = ~aFlat;        // R9: must be ignored
        bFlat = bFlat ^ {N*N{8'h5A}};
      end
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      check(done == (n == 7), "R4 done timing", int'(done), int'(n == 7));
    end
    checkResults(req);
    aFlat = ~aFlat;            // R9: idle input change
    bFlat = {N*N{8'h7F}};
    for (int n = 0; n < 2; n++) begin
      @(posedge clk); @(negedge clk);
      check(done == 1'b0, "R4 single pulse", int'(done), 0);
    end
    checkResults("R5 hold R9");
  endtask

  initial begin
    #(CLK_P * 200000);
    nFails++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 reset done", int'(done), 0);
    check(cFlat == '0, "R1 reset result", cOut(0, 0), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && cFlat == '0, "R1 idle", int'(done), 0);

    // R2 R3: identity times a distinct-valued matrix
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        am[r][c] = (r == c) ? 1 : 0;
        bm[r][c] = r * N + c - 4;
      end
    runCase(1'b0, "R2 identity left");
    // R2 R3: distinct matrix times identity
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        am[r][c] = 10 * r + c + 1;
        bm[r][c] = (r == c) ? 1 : 0;
      end
    runCase(1'b0, "R2 identity right");
    // R8: all four full-range sign combinations
    for (int s = 0; s < 4; s++) begin
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++) begin
          am[r][c] = s[0] ? 127 : -128;
          bm[r][c] = s[1] ? 127 : -128;
        end
      runCase(1'b0, "R8 full range");
    end
    // R6 R9: disturbance during a run
    for (int t = 0; t < 4; t++) begin
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++) begin
          am[r][c] = rnd8();
          bm[r][c] = rnd8();
        end
      runCase(1'b1, "R6 start ignored");
    end
    // R3: pseudo-random sweep
    for (int t = 0; t < 40; t++) begin
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++) begin
          am[r][c] = rnd8();
          bm[r][c] = rnd8();
        end
      runCase(1'b0, "R3 product");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule